// File: doc/BRIEF.md
# Privilege Mode and Banked Stack Control

This block keeps track of where a processor core is executing: in thread code or inside an exception handler, and at privileged or user level. It holds a two-bit control word. Its low bit demotes thread code to user level. Its high bit asks thread code to run on the process stack instead of the main stack. Handler code always runs privileged and always runs on the main stack.

The block stores both stack pointers and presents the active one on `sp_o`. A push or pop request produces a memory address in the same cycle, and the active pointer then moves by one word. Instruction decode, the memory and exception arbitration live elsewhere: they send entry and exit strobes, control-word writes, named stack-pointer writes and push or pop requests.

Requests that the current level does not allow are refused. The refused request changes nothing, and the block raises a one-cycle fault pulse.

Top module: `psc_priv_stack`

## Requirements
- R1: After reset the block is in thread mode at privileged level. `ctl_o` reads 0, `sp_o` reads 0, and `fault_o`, `stk_vld_o` and `psp_act_o` are 0.
- R2: When `ctl_o[0]` is 1 in thread mode, `priv_o` is 0. A control write at user level leaves the control word unchanged and drives `fault_o` high in the following cycle only.
- R3: A privileged thread-mode control write of `ctl_wdata_i[1]`=1 makes the process pointer active (`psp_act_o`=1, `sp_o` shows it). A control write in handler mode updates bit 0, keeps the stored bit 1 and raises no fault.
- R4: In handler mode `ctl_o[1]` reads 0 and `sp_o` shows the main pointer, whatever bit 1 stores.
- R5: An entry strobe makes `handler_o`=1 and `priv_o`=1 in the next cycle. An exit strobe in handler mode returns to the saved thread mode, and the level there follows control bit 0. An exit strobe in thread mode is ignored.
- R6: With control bit 1 at 0, thread code and handler code see the same main pointer.
- R7: A stack-pointer write with `sp_bank_i`=0 targets the main pointer, and with 1 it targets the process pointer. The low log2(WORD_BYTES) bits are stored as zero.
- R8: A push drives `stk_vld_o`=1, `stk_we_o`=1 and `stk_addr_o` = active - WORD_BYTES in the same cycle. The active pointer takes that value in the next cycle, with arithmetic modulo 2^SP_W.
- R9: A pop drives `stk_vld_o`=1, `stk_we_o`=0 and `stk_addr_o` = active pointer, and the pointer grows by WORD_BYTES in the next cycle. When a push and a pop are requested together, the push is performed.
- R10: A stack-pointer write at user level changes no pointer and pulses `fault_o` in the next cycle. Any `sp_wr_i` request blocks a push or pop in that cycle (`stk_vld_o`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_enter_i | input | 1 | Exception entry strobe |
| exc_exit_i | input | 1 | Exception return strobe |
| ctl_wr_i | input | 1 | Control word write request |
| ctl_wdata_i | input | 2 | Control word data: bit 0 user level, bit 1 process stack |
| sp_wr_i | input | 1 | Named stack-pointer write request |
| sp_bank_i | input | 1 | Pointer to write: 0 main, 1 process |
| sp_wdata_i | input | SP_W | Stack-pointer write data |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| handler_o | output | 1 | 1 in handler mode |
| priv_o | output | 1 | 1 at privileged level |
| ctl_o | output | 2 | Control word as read |
| psp_act_o | output | 1 | Process pointer is active |
| sp_o | output | SP_W | Active stack pointer |
| fault_o | output | 1 | One-cycle pulse for a refused request |
| stk_vld_o | output | 1 | Stack memory access this cycle |
| stk_we_o | output | 1 | Stack access is a write (push) |
| stk_addr_o | output | SP_W | Stack memory address |

## Verification
The bench builds the block with SP_W=16 and WORD_BYTES=4. The narrow pointer lets a push from address 0 wrap to 0xFFFC, and the pop back, within a couple of cycles. The two-bit alignment mask is exercised by odd write data. The test walks through both levels, both stacks and the handler round trip, so refusals, overrides and bit-1 masking all show up at the ports.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic {
    MODE_THREAD  = 1'b0,
    MODE_HANDLER = 1'b1
  } exec_mode_e;

  typedef struct packed {
    logic stk_sel;  // bit 1: process stack in thread code
    logic unpriv;   // bit 0: thread code runs at user level
  } ctl_word_t;
endpackage

// File: rtl/psc_mode_ctl.sv
module psc_mode_ctl
  import psc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exc_enter_i,
  input  logic       exc_exit_i,
  input  logic       ctl_wr_i,
  input  ctl_word_t  ctl_wdata_i,
  input  logic       sp_wr_i,
  output exec_mode_e mode_o,
  output logic       priv_o,
  output ctl_word_t  ctl_rd_o,
  output logic       use_psp_o,
  output logic       sp_wr_ok_o,
  output logic       fault_o
);
  exec_mode_e mode_q, mode_d, ret_mode_q;
  ctl_word_t  ctl_q, ctl_d;
  logic       fault_q, illegal;
  logic       mode_en, ret_en, ctl_en;
  logic       priv_w, in_thread;

  assign in_thread = (mode_q == MODE_THREAD);
  assign priv_w    = !in_thread || !ctl_q.unpriv;

  always_comb begin
    ctl_d   = ctl_q;
    ctl_en  = 1'b0;
    illegal = 1'b0;
    if (ctl_wr_i) begin
      if (!priv_w) begin
        illegal = 1'b1;
      end else begin
        ctl_en       = 1'b1;
        ctl_d.unpriv = ctl_wdata_i.unpriv;
        if (in_thread) ctl_d.stk_sel = ctl_wdata_i.stk_sel;
      end
    end
    if (sp_wr_i && !priv_w) illegal = 1'b1;
  end

  always_comb begin
    mode_d  = mode_q;
    mode_en = 1'b0;
    ret_en  = 1'b0;
    if (exc_enter_i) begin
      mode_d  = MODE_HANDLER;
      mode_en = 1'b1;
      ret_en  = 1'b1;
    end else if (exc_exit_i && !in_thread) begin
      mode_d  = ret_mode_q;
      mode_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_THREAD;
      ret_mode_q <= MODE_THREAD;
      ctl_q      <= '0;
      fault_q    <= 1'b0;
    end else begin
      if (mode_en) mode_q     <= mode_d;
      if (ret_en)  ret_mode_q <= mode_q;
      if (ctl_en)  ctl_q      <= ctl_d;
      fault_q <= illegal;
    end
  end

  assign mode_o           = mode_q;
  assign priv_o           = priv_w;
  assign ctl_rd_o.unpriv  = ctl_q.unpriv;
  assign ctl_rd_o.stk_sel = ctl_q.stk_sel && in_thread;
  assign use_psp_o        = ctl_q.stk_sel && in_thread;
  assign sp_wr_ok_o       = priv_w;
  assign fault_o          = fault_q;

  // R2: user-level control write refused and flagged
  a_r2_user_ctl_wr_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_i && !priv_w) |=> (fault_q && $stable(ctl_q)));
  // R5: entry lands in privileged handler mode
  a_r5_entry_priv: assert property (@(posedge clk) disable iff (!rst_n)
    exc_enter_i |=> (mode_q == MODE_HANDLER && priv_w));
  // R5: exit restores the saved mode
  a_r5_exit_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_exit_i && !exc_enter_i && !in_thread) |=> (mode_q == $past(ret_mode_q)));
  // R10: user-level pointer write flagged
  a_r10_user_sp_wr_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_wr_i && !priv_w) |=> fault_q);
endmodule

// File: rtl/psc_sp_bank.sv
module psc_sp_bank #(
  parameter int SP_W       = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_req_i,
  input  logic            wr_ok_i,
  input  logic            bank_i,
  input  logic [SP_W-1:0] wdata_i,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic            use_psp_i,
  output logic [SP_W-1:0] sp_o,
  output logic            stk_vld_o,
  output logic            stk_we_o,
  output logic [SP_W-1:0] stk_addr_o
);
  localparam int        NBANK      = 2;
  localparam logic [SP_W-1:0] STEP       = SP_W'(WORD_BYTES);
  localparam logic [SP_W-1:0] ALIGN_MASK = SP_W'(WORD_BYTES - 1);

  logic [SP_W-1:0] sp_all [NBANK];
  logic [SP_W-1:0] active, dec_v, inc_v, wr_aligned;
  logic            do_push, do_pop;

  assign active     = use_psp_i ? sp_all[1] : sp_all[0];
  assign dec_v      = active - STEP;
  assign inc_v      = active + STEP;
  assign wr_aligned = wdata_i & ~ALIGN_MASK;
  assign do_push    = push_i && !wr_req_i;
  assign do_pop     = pop_i && !push_i && !wr_req_i;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [SP_W-1:0] q, d;
    logic            wr_hit, stk_hit, en;

    assign wr_hit  = wr_req_i && wr_ok_i && (bank_i == 1'(b));
    assign stk_hit = (do_push || do_pop) && (use_psp_i == 1'(b));
    assign en      = wr_hit || stk_hit;

    always_comb begin
      if (wr_hit)       d = wr_aligned;
      else if (do_push) d = dec_v;
      else              d = inc_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign sp_all[b] = q;
  end

  assign sp_o       = active;
  assign stk_vld_o  = do_push || do_pop;
  assign stk_we_o   = do_push;
  assign stk_addr_o = do_push ? dec_v : active;

  // R7: both pointers stay word aligned
  a_r7_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ((sp_all[0] & ALIGN_MASK) == '0) && ((sp_all[1] & ALIGN_MASK) == '0));
  // R8: push on the main pointer steps it down one word
  a_r8_push_main: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !wr_req_i && !use_psp_i) |=> (sp_all[0] == $past(sp_all[0]) - STEP));
  // R8: push leaves the inactive pointer alone
  a_r8_push_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !wr_req_i && !use_psp_i) |=> $stable(sp_all[1]));
  // R9: pop on the process pointer steps it up one word
  a_r9_pop_proc: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !wr_req_i && use_psp_i) |=> (sp_all[1] == $past(sp_all[1]) + STEP));
endmodule

// File: rtl/psc_priv_stack.sv
module psc_priv_stack
  import psc_pkg::*;
#(
  parameter int SP_W       = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_enter_i,
  input  logic            exc_exit_i,
  input  logic            ctl_wr_i,
  input  logic [1:0]      ctl_wdata_i,
  input  logic            sp_wr_i,
  input  logic            sp_bank_i,
  input  logic [SP_W-1:0] sp_wdata_i,
  input  logic            push_i,
  input  logic            pop_i,
  output logic            handler_o,
  output logic            priv_o,
  output logic [1:0]      ctl_o,
  output logic            psp_act_o,
  output logic [SP_W-1:0] sp_o,
  output logic            fault_o,
  output logic            stk_vld_o,
  output logic            stk_we_o,
  output logic [SP_W-1:0] stk_addr_o
);
  exec_mode_e mode;
  ctl_word_t  ctl_rd;
  logic       use_psp, sp_wr_ok;

  psc_mode_ctl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_enter_i (exc_enter_i),
    .exc_exit_i  (exc_exit_i),
    .ctl_wr_i    (ctl_wr_i),
    .ctl_wdata_i (ctl_word_t'(ctl_wdata_i)),
    .sp_wr_i     (sp_wr_i),
    .mode_o      (mode),
    .priv_o      (priv_o),
    .ctl_rd_o    (ctl_rd),
    .use_psp_o   (use_psp),
    .sp_wr_ok_o  (sp_wr_ok),
    .fault_o     (fault_o)
  );

  psc_sp_bank #(
    .SP_W       (SP_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_req_i   (sp_wr_i),
    .wr_ok_i    (sp_wr_ok),
    .bank_i     (sp_bank_i),
    .wdata_i    (sp_wdata_i),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .use_psp_i  (use_psp),
    .sp_o       (sp_o),
    .stk_vld_o  (stk_vld_o),
    .stk_we_o   (stk_we_o),
    .stk_addr_o (stk_addr_o)
  );

  assign handler_o = (mode == MODE_HANDLER);
  assign ctl_o     = ctl_rd;
  assign psp_act_o = use_psp;

  // R4: handler code never runs on the process pointer
  a_r4_handler_main_stack: assert property (@(posedge clk) disable iff (!rst_n)
    handler_o |-> (!psp_act_o && !ctl_o[1]));
endmodule

// File: tb/sim_psc_priv_stack.sv
module sim_psc_priv_stack;
  localparam int CLK_PERIOD = 10;
  localparam int SP_W = 16;
  localparam int S_HND = 0, S_PRV = 1, S_CTL = 2, S_SP = 3, S_FLT = 4,
                 S_VLD = 5, S_WE = 6, S_ADR = 7, S_PSP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ent = 0, ext = 0, cw = 0, sw = 0, sb = 0, pu = 0, po = 0;
  logic [1:0] cd = '0;
  logic [SP_W-1:0] sd = '0;
  logic hnd, prv, psp, flt, vld, we;
  logic [1:0] ctl;
  logic [SP_W-1:0] sp, adr;

  typedef struct {
    int          cyc;
    int          sig;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t items[$];
  int cnt = 0, now = 0, n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  psc_priv_stack #(.SP_W(SP_W), .WORD_BYTES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .exc_enter_i(ent), .exc_exit_i(ext),
    .ctl_wr_i(cw), .ctl_wdata_i(cd), .sp_wr_i(sw), .sp_bank_i(sb),
    .sp_wdata_i(sd), .push_i(pu), .pop_i(po), .handler_o(hnd),
    .priv_o(prv), .ctl_o(ctl), .psp_act_o(psp), .sp_o(sp), .fault_o(flt),
    .stk_vld_o(vld), .stk_we_o(we), .stk_addr_o(adr)
  );

  function automatic logic [31:0] sample(int s);
    case (s)
      S_HND:   return 32'(hnd);
      S_PRV:   return 32'(prv);
      S_CTL:   return 32'(ctl);
      S_SP:    return 32'(sp);
      S_FLT:   return 32'(flt);
      S_VLD:   return 32'(vld);
      S_WE:    return 32'(we);
      S_ADR:   return 32'(adr);
      default: return 32'(psp);
    endcase
  endfunction

  // monitor: compares queued expectations in the cycle they fall due
  always begin
    @(negedge clk);
    #3;
    while (items.size() > 0 && items[0].cyc == cnt) begin
      item_t it;
      logic [31:0] got;
      it  = items.pop_front();
      got = sample(it.sig);
      n_chk++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s sig=%0d cycle=%0d got=%h exp=%h", it.req, it.sig, cnt, got, it.exp);
      end
    end
    cnt++;
  end

  task automatic step(input logic e, x, c, input logic [1:0] d, input logic w,
                      input logic b, input logic [SP_W-1:0] v, input logic u, input logic o);
    @(negedge clk);
    #1;
    ent = e; ext = x; cw = c; cd = d; sw = w; sb = b; sd = v; pu = u; po = o;
    now = cnt;
  endtask

  task automatic idle();
    step(0, 0, 0, 2'b00, 0, 0, '0, 0, 0);
  endtask

  task automatic ex(int off, int sig, logic [31:0] v, string r);
    items.push_back('{now + off, sig, v, r});
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    idle();
    ex(0, S_HND, 0, "R1"); ex(0, S_PRV, 1, "R1"); ex(0, S_CTL, 0, "R1");
    ex(0, S_SP, 0, "R1"); ex(0, S_FLT, 0, "R1"); ex(0, S_VLD, 0, "R1");
    ex(0, S_PSP, 0, "R1");
    // R7 named writes with alignment
    step(0, 0, 0, 2'b00, 1, 0, 16'h1003, 0, 0); ex(1, S_SP, 16'h1000, "R7");
    step(0, 0, 0, 2'b00, 1, 1, 16'h2006, 0, 0); ex(1, S_SP, 16'h1000, "R7");
    ex(1, S_FLT, 0, "R7");
    // R3 select process stack
    step(0, 0, 1, 2'b10, 0, 0, '0, 0, 0);
    ex(1, S_CTL, 2, "R3"); ex(1, S_PSP, 1, "R3"); ex(1, S_SP, 16'h2004, "R3");
    ex(1, S_PRV, 1, "R3");
    // R8 push on process stack
    step(0, 0, 0, 2'b00, 0, 0, '0, 1, 0);
    ex(0, S_ADR, 16'h2000, "R8"); ex(0, S_WE, 1, "R8"); ex(0, S_VLD, 1, "R8");
    ex(1, S_SP, 16'h2000, "R8");
    // R4 / R5 entry
    step(1, 0, 0, 2'b00, 0, 0, '0, 0, 0);
    ex(1, S_HND, 1, "R5"); ex(1, S_PRV, 1, "R5"); ex(1, S_CTL, 0, "R4");
    ex(1, S_SP, 16'h1000, "R4");
    step(0, 0, 0, 2'b00, 0, 0, '0, 1, 0);
    ex(0, S_ADR, 16'h0FFC, "R8"); ex(1, S_SP, 16'h0FFC, "R8");
    // R3 handler write: bit0 taken, bit1 kept, no fault
    step(0, 0, 1, 2'b01, 0, 0, '0, 0, 0);
    ex(1, S_CTL, 1, "R3"); ex(1, S_FLT, 0, "R3"); ex(1, S_PRV, 1, "R3");
    // R5 exit to user thread on process stack
    step(0, 1, 0, 2'b00, 0, 0, '0, 0, 0);
    ex(1, S_HND, 0, "R5"); ex(1, S_PRV, 0, "R2"); ex(1, S_CTL, 3, "R5");
    ex(1, S_SP, 16'h2000, "R5");
    // R2 refused write
    step(0, 0, 1, 2'b00, 0, 0, '0, 0, 0);
    ex(1, S_FLT, 1, "R2"); ex(1, S_CTL, 3, "R2");
    idle(); ex(1, S_FLT, 0, "R2");
    // R10 refused pointer write
    step(0, 0, 0, 2'b00, 1, 0, 16'h5550, 0, 0);
    ex(1, S_FLT, 1, "R10"); ex(1, S_SP, 16'h2000, "R10");
    // R9 pop
    step(0, 0, 0, 2'b00, 0, 0, '0, 0, 1);
    ex(0, S_ADR, 16'h2000, "R9"); ex(0, S_WE, 0, "R9"); ex(0, S_VLD, 1, "R9");
    ex(1, S_SP, 16'h2004, "R9");
    step(0, 0, 0, 2'b00, 0, 0, '0, 1, 1);
    ex(0, S_ADR, 16'h2000, "R9"); ex(0, S_WE, 1, "R9"); ex(1, S_SP, 16'h2000, "R9");
    // R10 write request blocks push
    step(0, 0, 0, 2'b00, 1, 0, 16'h1234, 1, 0);
    ex(0, S_VLD, 0, "R10"); ex(1, S_FLT, 1, "R10"); ex(1, S_SP, 16'h2000, "R10");
    // R5 exit in thread ignored
    step(0, 1, 0, 2'b00, 0, 0, '0, 0, 0);
    ex(1, S_HND, 0, "R5"); ex(1, S_PRV, 0, "R5");
    step(1, 0, 0, 2'b00, 0, 0, '0, 0, 0);
    ex(1, S_HND, 1, "R5"); ex(1, S_SP, 16'h0FFC, "R10"); ex(1, S_CTL, 1, "R4");
    step(0, 0, 1, 2'b00, 0, 0, '0, 0, 0);
    ex(1, S_CTL, 0, "R3"); ex(1, S_FLT, 0, "R3");
    step(0, 1, 0, 2'b00, 0, 0, '0, 0, 0);
    ex(1, S_HND, 0, "R5"); ex(1, S_PRV, 1, "R5"); ex(1, S_CTL, 2, "R5");
    ex(1, S_SP, 16'h2000, "R5"); ex(1, S_PSP, 1, "R5");
    // R6 shared main stack
    step(0, 0, 1, 2'b00, 0, 0, '0, 0, 0);
    ex(1, S_CTL, 0, "R6"); ex(1, S_PSP, 0, "R6"); ex(1, S_SP, 16'h0FFC, "R6");
    step(0, 0, 0, 2'b00, 1, 0, 16'h0002, 0, 0); ex(1, S_SP, 0, "R7");
    // R8 / R9 wrap
    step(0, 0, 0, 2'b00, 0, 0, '0, 1, 0);
    ex(0, S_ADR, 16'hFFFC, "R8"); ex(0, S_WE, 1, "R8"); ex(1, S_SP, 16'hFFFC, "R8");
    step(0, 0, 0, 2'b00, 0, 0, '0, 0, 1);
    ex(0, S_ADR, 16'hFFFC, "R9"); ex(0, S_WE, 0, "R9"); ex(1, S_SP, 0, "R9");
    step(1, 0, 0, 2'b00, 0, 0, '0, 0, 0);
    ex(1, S_HND, 1, "R6"); ex(1, S_SP, 0, "R6"); ex(1, S_PSP, 0, "R6");
    idle();
    idle();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule